// File: doc/BRIEF.md
# Virtualization-Aware Trap Router

This unit decides where a trap is handled on a core that supports a hypervisor layer, and commits the status fields that the trap changes. It receives a trap event, which is a cause code plus a flag that marks it as an interrupt or an exception. It also receives the current privilege, the virtualization state, the delegation masks of the machine and hypervisor stages, and the bits of the current status that the trap must save.

It picks one of three handling levels: machine, hypervisor-supervisor, or virtual-supervisor. It renumbers environment calls by their origin. It then registers the final cause, the target level and the new saved-state fields.

When `trap_valid_i` is high, the registered outputs take the values for that trap on the next clock edge. At all other times they hold. One cycle after a trap that leaves a virtualized context for a host level, `swap_o` pulses for one cycle. This tells the surrounding core to exchange its banked supervisor and virtual-supervisor register sets. With `HYP_EN` = 0 the hypervisor paths are removed, and every delegated trap goes to the supervisor level.

Top module: `trap_router`

## Requirements
- R1: An exception with cause 8 (environment call) is renumbered by its origin. Privilege 3 (M) gives 11. Privilege 1 (S) gives 10 with virtualization on and 9 with it off. Privilege 0 (U) keeps 8. Interrupts and all other causes pass through unchanged to `cause_o`.
- R2: A trap leaves machine level only when the privilege is 0 or 1, the cause is below XLEN, and the cause bit is set in the machine mask. That mask is `mideleg_i` for interrupts and `medeleg_i` for exceptions. Any other trap targets M (`target_o` = 3).
- R3: A trap delegated below M goes to the virtual-supervisor level (`target_o` = 2) exactly when three things hold: virtualization is on, the cause bit is set in the hypervisor mask (`hideleg_i` or `hedeleg_i` by trap type), and the force flag is clear. Such a trap keeps virtualization on, does not change the second-level fields, and gives no swap.
- R4: A trap from a virtualized context that lands at the hypervisor-supervisor level (`target_o` = 1) does three things. It shifts `spv_i` into `sp2v_o` and `spp_i` into `sp2p_o`, and sets `spv_o` to 1. It clears virtualization and the force flag. It pulses `swap_o` for one cycle.
- R5: A hypervisor-supervisor trap from a non-virtualized context does the same field shift (with `spv_o` = 0). It keeps the force flag, and gives no swap.
- R6: A machine-level trap sets `mpv_o` to the virtualization bit and `mtl_o` to the force flag. It clears virtualization and the force flag, and pulses `swap_o` exactly when virtualization was on.
- R7: A trap to either supervisor level sets `priv_o` to 1, `spie_o` to `sie_i`, and `spp_o` to 1 when the trap came from S or 0 when it came from U.
- R8: A machine-level trap sets `priv_o` to 3, `mpie_o` to `mie_i`, and `mpp_o` to the trapping privilege.
- R9: Without `trap_valid_i`, all registered outputs hold their values and `swap_o` is 0.
- R10: Reset sets `priv_o` to 3, `target_o` to 3, and every other output to 0.
- R11: With `HYP_EN` = 0, delegated traps target level 1 regardless of the hypervisor masks and virtualization. The second-level fields, `mpv_o`, `mtl_o` and `swap_o` stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| trap_valid_i | input | 1 | Commit a trap this cycle |
| trap_async_i | input | 1 | 1 = interrupt, 0 = exception |
| trap_cause_i | input | CAUSE_W | Raw cause code |
| mideleg_i | input | XLEN | Machine-stage interrupt delegation mask |
| medeleg_i | input | XLEN | Machine-stage exception delegation mask |
| hideleg_i | input | XLEN | Hypervisor-stage interrupt delegation mask |
| hedeleg_i | input | XLEN | Hypervisor-stage exception delegation mask |
| priv_i | input | 2 | Current privilege (0 U, 1 S, 3 M) |
| virt_i | input | 1 | Virtualization on |
| force_hs_i | input | 1 | Force trap to hypervisor level |
| sie_i | input | 1 | Current supervisor interrupt enable |
| mie_i | input | 1 | Current machine interrupt enable |
| spp_i | input | 1 | Current supervisor previous privilege |
| spv_i | input | 1 | Current saved virtualization bit |
| cause_o | output | CAUSE_W | Final cause code |
| target_o | output | 2 | Handling level (1 HS/S, 2 VS, 3 M) |
| priv_o | output | 2 | Privilege after the trap |
| virt_o | output | 1 | Virtualization after the trap |
| force_hs_o | output | 1 | Force flag after the trap |
| spie_o | output | 1 | Supervisor previous interrupt enable |
| spp_o | output | 1 | Supervisor previous privilege |
| mpie_o | output | 1 | Machine previous interrupt enable |
| mpp_o | output | 2 | Machine previous privilege |
| spv_o | output | 1 | Saved virtualization bit |
| sp2v_o | output | 1 | Second-level saved virtualization |
| sp2p_o | output | 1 | Second-level saved privilege |
| mpv_o | output | 1 | Machine previous virtualization |
| mtl_o | output | 1 | Machine trap-level (force flag at trap) |
| swap_o | output | 1 | One-cycle request to exchange banked register sets |

## Verification
All outputs are registered, so a wrong target decision or a wrong field update shows at the ports on the first clock edge after the strobe, and it stays visible until the next trap. A fault in the two-level stack is the least visible kind: a wrong `sp2v_o` or `sp2p_o` only shows at a hypervisor-level trap, so the sequence of directed traps moves known values through the stack and checks every stage. A swap fault shows as a missing pulse, or as a pulse that lasts longer than one cycle.

// File: rtl/trap_router_pkg.sv
package trap_router_pkg;
  localparam logic [1:0] PRV_U = 2'd0;
  localparam logic [1:0] PRV_S = 2'd1;
  localparam logic [1:0] PRV_M = 2'd3;

  localparam int unsigned ECALL_U  = 8;
  localparam int unsigned ECALL_S  = 9;
  localparam int unsigned ECALL_VS = 10;
  localparam int unsigned ECALL_M  = 11;

  typedef enum logic [1:0] {
    TGT_NONE = 2'd0,
    TGT_HS   = 2'd1,
    TGT_VS   = 2'd2,
    TGT_M    = 2'd3
  } tgt_e;
endpackage

// File: rtl/trap_cause_map.sv
module trap_cause_map
  import trap_router_pkg::*;
#(
  parameter int unsigned CAUSE_W = 7
) (
  input  logic               async_i,
  input  logic [CAUSE_W-1:0] cause_i,
  input  logic [1:0]         priv_i,
  input  logic               virt_i,
  output logic [CAUSE_W-1:0] cause_o
);
  always_comb begin
    cause_o = cause_i;
    if (!async_i && cause_i == CAUSE_W'(ECALL_U)) begin
      unique case (priv_i)
        PRV_M:   cause_o = CAUSE_W'(ECALL_M);
        PRV_S:   cause_o = virt_i ? CAUSE_W'(ECALL_VS) : CAUSE_W'(ECALL_S);
        default: cause_o = cause_i;
      endcase
    end
  end
endmodule

// File: rtl/trap_deleg_sel.sv
module trap_deleg_sel
  import trap_router_pkg::*;
#(
  parameter int unsigned XLEN    = 64,
  parameter int unsigned CAUSE_W = 7,
  parameter bit          HYP_EN  = 1'b1
) (
  input  logic               async_i,
  input  logic [CAUSE_W-1:0] cause_i,
  input  logic [XLEN-1:0]    mideleg_i,
  input  logic [XLEN-1:0]    medeleg_i,
  input  logic [XLEN-1:0]    hideleg_i,
  input  logic [XLEN-1:0]    hedeleg_i,
  input  logic [1:0]         priv_i,
  input  logic               virt_i,
  input  logic               force_hs_i,
  output tgt_e               tgt_o
);
  localparam int unsigned IDX_W = $clog2(XLEN);

  logic             in_range;
  logic [IDX_W-1:0] idx;
  logic [XLEN-1:0]  m_mask;
  logic             m_hit;

  assign in_range = {{(32-CAUSE_W){1'b0}}, cause_i} < 32'(XLEN);
  assign idx      = cause_i[IDX_W-1:0];
  assign m_mask   = async_i ? mideleg_i : medeleg_i;
  assign m_hit    = (priv_i <= PRV_S) && in_range && m_mask[idx];

  generate
    if (HYP_EN) begin : g_hyp
      logic [XLEN-1:0] h_mask;
      logic            vs_hit;
      assign h_mask = async_i ? hideleg_i : hedeleg_i;
      assign vs_hit = virt_i && h_mask[idx] && !force_hs_i;
      assign tgt_o  = !m_hit ? TGT_M : (vs_hit ? TGT_VS : TGT_HS);
    end else begin : g_nohyp
      logic unused_h;
      assign unused_h = ^{hideleg_i, hedeleg_i, virt_i, force_hs_i};
      assign tgt_o    = m_hit ? TGT_HS : TGT_M;
    end
  endgenerate
endmodule

// File: rtl/trap_state_upd.sv
module trap_state_upd
  import trap_router_pkg::*;
#(
  parameter int unsigned CAUSE_W = 7,
  parameter bit          HYP_EN  = 1'b1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               trap_valid_i,
  input  tgt_e               tgt_i,
  input  logic [CAUSE_W-1:0] cause_i,
  input  logic [1:0]         priv_i,
  input  logic               virt_i,
  input  logic               force_hs_i,
  input  logic               sie_i,
  input  logic               mie_i,
  input  logic               spp_i,
  input  logic               spv_i,
  output logic [CAUSE_W-1:0] cause_o,
  output logic [1:0]         target_o,
  output logic [1:0]         priv_o,
  output logic               virt_o,
  output logic               force_hs_o,
  output logic               spie_o,
  output logic               spp_o,
  output logic               mpie_o,
  output logic [1:0]         mpp_o,
  output logic               spv_o,
  output logic               sp2v_o,
  output logic               sp2p_o,
  output logic               mpv_o,
  output logic               mtl_o,
  output logic               swap_o
);
  logic [CAUSE_W-1:0] cause_q, cause_d;
  tgt_e               tgt_q, tgt_d;
  logic [1:0]         priv_q, priv_d, mpp_q, mpp_d;
  logic virt_q, virt_d, force_q, force_d, spie_q, spie_d, spp_q, spp_d;
  logic mpie_q, mpie_d, spv_q, spv_d, sp2v_q, sp2v_d, sp2p_q, sp2p_d;
  logic mpv_q, mpv_d, mtl_q, mtl_d, swap_q, swap_d;

  always_comb begin
    cause_d = cause_q;  tgt_d  = tgt_q;   priv_d = priv_q;  virt_d = virt_q;
    force_d = force_q;  spie_d = spie_q;  spp_d  = spp_q;   mpie_d = mpie_q;
    mpp_d   = mpp_q;    spv_d  = spv_q;   sp2v_d = sp2v_q;  sp2p_d = sp2p_q;
    mpv_d   = mpv_q;    mtl_d  = mtl_q;   swap_d = 1'b0;
    if (trap_valid_i) begin
      cause_d = cause_i;
      tgt_d   = tgt_i;
      unique case (tgt_i)
        TGT_M: begin
          priv_d  = PRV_M;
          mpie_d  = mie_i;
          mpp_d   = priv_i;
          virt_d  = 1'b0;
          force_d = 1'b0;
          if (HYP_EN) begin
            mpv_d  = virt_i;
            mtl_d  = force_hs_i;
            swap_d = virt_i;
          end
        end
        TGT_VS: begin
          priv_d  = PRV_S;
          spie_d  = sie_i;
          spp_d   = priv_i[0];
          virt_d  = virt_i;
          force_d = force_hs_i;
        end
        default: begin
          priv_d = PRV_S;
          spie_d = sie_i;
          spp_d  = priv_i[0];
          if (HYP_EN) begin
            // two-deep saved-state push
            sp2v_d  = spv_i;
            sp2p_d  = spp_i;
            spv_d   = virt_i;
            swap_d  = virt_i;
            virt_d  = 1'b0;
            force_d = virt_i ? 1'b0 : force_hs_i;
          end else begin
            virt_d  = 1'b0;
            force_d = 1'b0;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cause_q <= '0;    tgt_q  <= TGT_M;  priv_q <= PRV_M;  virt_q <= 1'b0;
      force_q <= 1'b0;  spie_q <= 1'b0;   spp_q  <= 1'b0;   mpie_q <= 1'b0;
      mpp_q   <= 2'd0;  spv_q  <= 1'b0;   sp2v_q <= 1'b0;   sp2p_q <= 1'b0;
      mpv_q   <= 1'b0;  mtl_q  <= 1'b0;   swap_q <= 1'b0;
    end else begin
      cause_q <= cause_d; tgt_q  <= tgt_d;  priv_q <= priv_d; virt_q <= virt_d;
      force_q <= force_d; spie_q <= spie_d; spp_q  <= spp_d;  mpie_q <= mpie_d;
      mpp_q   <= mpp_d;   spv_q  <= spv_d;  sp2v_q <= sp2v_d; sp2p_q <= sp2p_d;
      mpv_q   <= mpv_d;   mtl_q  <= mtl_d;  swap_q <= swap_d;
    end
  end

  assign cause_o = cause_q;  assign target_o = tgt_q;  assign priv_o = priv_q;
  assign virt_o  = virt_q;   assign force_hs_o = force_q;
  assign spie_o  = spie_q;   assign spp_o  = spp_q;    assign mpie_o = mpie_q;
  assign mpp_o   = mpp_q;    assign spv_o  = spv_q;    assign sp2v_o = sp2v_q;
  assign sp2p_o  = sp2p_q;   assign mpv_o  = mpv_q;    assign mtl_o  = mtl_q;
  assign swap_o  = swap_q;

  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !trap_valid_i |=> $stable(priv_o) && $stable(virt_o) && $stable(force_hs_o)
                      && $stable(sp2v_o) && $stable(mpv_o) && $stable(cause_o));
  p_swap_only_trap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !trap_valid_i |=> !swap_o);
  p_m_clears_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_valid_i && tgt_i == TGT_M |=>
      !virt_o && !force_hs_o && priv_o == PRV_M && mpp_o == $past(priv_i));
  p_hs_shift_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_valid_i && tgt_i == TGT_HS && HYP_EN |=>
      sp2v_o == $past(spv_i) && spv_o == $past(virt_i) && priv_o == PRV_S);
  p_vs_stay_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_valid_i && tgt_i == TGT_VS |=> virt_o && !swap_o);
endmodule

// File: rtl/trap_router.sv
module trap_router
  import trap_router_pkg::*;
#(
  parameter int unsigned XLEN    = 64,
  parameter int unsigned CAUSE_W = 7,
  parameter bit          HYP_EN  = 1'b1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               trap_valid_i,
  input  logic               trap_async_i,
  input  logic [CAUSE_W-1:0] trap_cause_i,
  input  logic [XLEN-1:0]    mideleg_i,
  input  logic [XLEN-1:0]    medeleg_i,
  input  logic [XLEN-1:0]    hideleg_i,
  input  logic [XLEN-1:0]    hedeleg_i,
  input  logic [1:0]         priv_i,
  input  logic               virt_i,
  input  logic               force_hs_i,
  input  logic               sie_i,
  input  logic               mie_i,
  input  logic               spp_i,
  input  logic               spv_i,
  output logic [CAUSE_W-1:0] cause_o,
  output logic [1:0]         target_o,
  output logic [1:0]         priv_o,
  output logic               virt_o,
  output logic               force_hs_o,
  output logic               spie_o,
  output logic               spp_o,
  output logic               mpie_o,
  output logic [1:0]         mpp_o,
  output logic               spv_o,
  output logic               sp2v_o,
  output logic               sp2p_o,
  output logic               mpv_o,
  output logic               mtl_o,
  output logic               swap_o
);
  logic [CAUSE_W-1:0] cause_m;
  tgt_e               tgt;

  trap_cause_map #(.CAUSE_W(CAUSE_W)) u_map (
    .async_i(trap_async_i), .cause_i(trap_cause_i), .priv_i(priv_i),
    .virt_i(virt_i), .cause_o(cause_m)
  );

  trap_deleg_sel #(.XLEN(XLEN), .CAUSE_W(CAUSE_W), .HYP_EN(HYP_EN)) u_sel (
    .async_i(trap_async_i), .cause_i(cause_m),
    .mideleg_i(mideleg_i), .medeleg_i(medeleg_i),
    .hideleg_i(hideleg_i), .hedeleg_i(hedeleg_i),
    .priv_i(priv_i), .virt_i(virt_i), .force_hs_i(force_hs_i), .tgt_o(tgt)
  );

  trap_state_upd #(.CAUSE_W(CAUSE_W), .HYP_EN(HYP_EN)) u_upd (
    .clk_i(clk_i), .rst_ni(rst_ni), .trap_valid_i(trap_valid_i),
    .tgt_i(tgt), .cause_i(cause_m), .priv_i(priv_i), .virt_i(virt_i),
    .force_hs_i(force_hs_i), .sie_i(sie_i), .mie_i(mie_i), .spp_i(spp_i),
    .spv_i(spv_i), .cause_o(cause_o), .target_o(target_o), .priv_o(priv_o),
    .virt_o(virt_o), .force_hs_o(force_hs_o), .spie_o(spie_o), .spp_o(spp_o),
    .mpie_o(mpie_o), .mpp_o(mpp_o), .spv_o(spv_o), .sp2v_o(sp2v_o),
    .sp2p_o(sp2p_o), .mpv_o(mpv_o), .mtl_o(mtl_o), .swap_o(swap_o)
  );

  p_m_gate_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_valid_i && priv_i == PRV_M |=> target_o == TGT_M);
  p_ecall_m_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_valid_i && !trap_async_i && trap_cause_i == CAUSE_W'(ECALL_U)
      && priv_i == PRV_M |=> cause_o == CAUSE_W'(ECALL_M));
  p_no_hyp_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !HYP_EN |-> !swap_o && !sp2v_o && !mpv_o && target_o != TGT_VS);
endmodule

// File: tb/sim_trap_router.sv
module sim_trap_router;
  localparam int XL = 64;
  localparam int CW = 7;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic tv = 1'b0, as = 1'b0;
  logic [CW-1:0] cause = '0;
  logic [XL-1:0] mid = '0, med = '0, hid = '0, hed = '0;
  logic [1:0] priv = 2'd0;
  logic virt = 0, frc = 0, sie = 0, mie = 0, spp = 0, spv = 0;

  logic [CW-1:0] c0, c1;
  logic [1:0] t0, p0, mpp0, t1, p1, mpp1;
  logic v0, f0, spie0, spp0, mpie0, spv0, sp2v0, sp2p0, mpv0, mtl0, sw0;
  logic v1, f1, spie1, spp1, mpie1, spv1, sp2v1, sp2p1, mpv1, mtl1, sw1;

  int checks = 0, failures = 0;
  bit done = 0;

  always #5ns clk = ~clk;

  trap_router #(.XLEN(XL), .CAUSE_W(CW), .HYP_EN(1'b1)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .trap_valid_i(tv), .trap_async_i(as),
    .trap_cause_i(cause), .mideleg_i(mid), .medeleg_i(med), .hideleg_i(hid),
    .hedeleg_i(hed), .priv_i(priv), .virt_i(virt), .force_hs_i(frc),
    .sie_i(sie), .mie_i(mie), .spp_i(spp), .spv_i(spv),
    .cause_o(c0), .target_o(t0), .priv_o(p0), .virt_o(v0), .force_hs_o(f0),
    .spie_o(spie0), .spp_o(spp0), .mpie_o(mpie0), .mpp_o(mpp0), .spv_o(spv0),
    .sp2v_o(sp2v0), .sp2p_o(sp2p0), .mpv_o(mpv0), .mtl_o(mtl0), .swap_o(sw0));

  trap_router #(.XLEN(XL), .CAUSE_W(CW), .HYP_EN(1'b0)) u1 (
    .clk_i(clk), .rst_ni(rst_ni), .trap_valid_i(tv), .trap_async_i(as),
    .trap_cause_i(cause), .mideleg_i(mid), .medeleg_i(med), .hideleg_i(hid),
    .hedeleg_i(hed), .priv_i(priv), .virt_i(virt), .force_hs_i(frc),
    .sie_i(sie), .mie_i(mie), .spp_i(spp), .spv_i(spv),
    .cause_o(c1), .target_o(t1), .priv_o(p1), .virt_o(v1), .force_hs_o(f1),
    .spie_o(spie1), .spp_o(spp1), .mpie_o(mpie1), .mpp_o(mpp1), .spv_o(spv1),
    .sp2v_o(sp2v1), .sp2p_o(sp2p1), .mpv_o(mpv1), .mtl_o(mtl1), .swap_o(sw1));

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // drive one trap at a negedge; outputs are registered on the following posedge
  task automatic trap(logic a, int cs, logic [1:0] pr, logic vi, logic fo,
                      logic si, logic mi, logic sp, logic sv);
    @(negedge clk);
    as = a; cause = CW'(cs); priv = pr; virt = vi; frc = fo;
    sie = si; mie = mi; spp = sp; spv = sv; tv = 1'b1;
    @(negedge clk);
    tv = 1'b0;
  endtask

  task automatic t_reset;
    chk("R10", "priv", 32'(p0), 3);   chk("R10", "target", 32'(t0), 3);
    chk("R10", "cause", 32'(c0), 0);  chk("R10", "virt", 32'(v0), 0);
    chk("R10", "sp2v", 32'(sp2v0), 0); chk("R10", "mpv", 32'(mpv0), 0);
    chk("R10", "swap", 32'(sw0), 0);
  endtask

  task automatic t_u_ecall_hs;
    med = '0; med[8] = 1'b1; mid = '0; hid = '0; hed = '0;
    trap(0, 8, 2'd0, 0, 1, 1, 0, 1, 1);
    chk("R1", "cause U", 32'(c0), 8);
    chk("R5", "target", 32'(t0), 1);  chk("R7", "priv", 32'(p0), 1);
    chk("R7", "spie", 32'(spie0), 1); chk("R7", "spp", 32'(spp0), 0);
    chk("R5", "sp2v", 32'(sp2v0), 1); chk("R5", "sp2p", 32'(sp2p0), 1);
    chk("R5", "spv", 32'(spv0), 0);   chk("R5", "force kept", 32'(f0), 1);
    chk("R5", "swap", 32'(sw0), 0);
  endtask

  task automatic t_vs_ecall;
    med = '0; med[10] = 1'b1; hed = '0; hed[10] = 1'b1;
    trap(0, 8, 2'd1, 1, 0, 0, 0, 0, 0);
    chk("R1", "cause VS", 32'(c0), 10);
    chk("R3", "target", 32'(t0), 2);  chk("R3", "virt", 32'(v0), 1);
    chk("R3", "sp2v held", 32'(sp2v0), 1); chk("R3", "spv held", 32'(spv0), 0);
    chk("R7", "spp", 32'(spp0), 1);   chk("R3", "swap", 32'(sw0), 0);
  endtask

  task automatic t_forced_hs;
    trap(0, 8, 2'd1, 1, 1, 0, 0, 0, 1);
    chk("R4", "target", 32'(t0), 1);  chk("R4", "virt", 32'(v0), 0);
    chk("R4", "force", 32'(f0), 0);   chk("R4", "swap", 32'(sw0), 1);
    chk("R4", "sp2v", 32'(sp2v0), 1); chk("R4", "sp2p", 32'(sp2p0), 0);
    chk("R4", "spv", 32'(spv0), 1);   chk("R1", "cause", 32'(c0), 10);
    @(negedge clk);
    chk("R4", "swap one cycle", 32'(sw0), 0);
  endtask

  task automatic t_m_ecall;
    trap(0, 8, 2'd3, 0, 1, 0, 1, 0, 0);
    chk("R1", "cause M", 32'(c0), 11); chk("R8", "target", 32'(t0), 3);
    chk("R8", "priv", 32'(p0), 3);     chk("R8", "mpie", 32'(mpie0), 1);
    chk("R8", "mpp", 32'(mpp0), 3);    chk("R6", "mpv", 32'(mpv0), 0);
    chk("R6", "mtl", 32'(mtl0), 1);    chk("R6", "force", 32'(f0), 0);
    chk("R6", "swap", 32'(sw0), 0);
  endtask

  task automatic t_m_from_virt;
    mid = '0;
    trap(1, 5, 2'd1, 1, 0, 0, 0, 0, 0);
    chk("R6", "target", 32'(t0), 3); chk("R6", "mpv", 32'(mpv0), 1);
    chk("R6", "mtl", 32'(mtl0), 0);  chk("R6", "swap", 32'(sw0), 1);
    chk("R6", "virt", 32'(v0), 0);   chk("R8", "mpp", 32'(mpp0), 1);
    chk("R1", "irq cause", 32'(c0), 5);
  endtask

  task automatic t_range;
    mid = '1; med = '1; hid = '1; hed = '1;
    trap(0, 70, 2'd0, 0, 0, 0, 0, 0, 0);
    chk("R2", "cause>=XLEN target", 32'(t0), 3);
    chk("R2", "cause", 32'(c0), 70);
    trap(0, 63, 2'd0, 1, 0, 0, 0, 0, 0);
    chk("R2", "cause 63 target", 32'(t0), 2);
  endtask

  task automatic t_async_masks;
    mid = '0; mid[9] = 1'b1; med = '0; hid = '0; hid[9] = 1'b1; hed = '0;
    trap(1, 9, 2'd0, 1, 0, 0, 0, 0, 0);
    chk("R2", "irq via mideleg", 32'(t0), 2);
    chk("R1", "irq 9 kept", 32'(c0), 9);
    mid = '0; mid[8] = 1'b1;
    trap(1, 8, 2'd1, 0, 0, 0, 0, 0, 0);
    chk("R1", "irq 8 kept", 32'(c0), 8);
    chk("R2", "irq 8 target", 32'(t0), 1);
  endtask

  task automatic t_hold;
    logic [31:0] sc, st, sp, ss;
    sc = 32'(c0); st = 32'(t0); sp = 32'(sp2v0); ss = 32'(spv0);
    @(negedge clk);
    as = 0; cause = CW'(11); priv = 2'd3; virt = 1; frc = 1; spv = 1; spp = 1;
    repeat (3) @(negedge clk);
    chk("R9", "cause", 32'(c0), sc);  chk("R9", "target", 32'(t0), st);
    chk("R9", "sp2v", 32'(sp2v0), sp); chk("R9", "spv", 32'(spv0), ss);
    chk("R9", "swap", 32'(sw0), 0);
  endtask

  task automatic t_no_hyp;
    med = '0; med[2] = 1'b1; hed = '0; hed[2] = 1'b1; mid = '0; hid = '0;
    trap(0, 2, 2'd1, 1, 0, 0, 0, 0, 1);
    chk("R11", "target", 32'(t1), 1); chk("R11", "virt", 32'(v1), 0);
    chk("R11", "sp2v", 32'(sp2v1), 0); chk("R11", "swap", 32'(sw1), 0);
    chk("R11", "hyp target", 32'(t0), 2);
    trap(0, 3, 2'd1, 1, 1, 0, 1, 0, 0);
    chk("R11", "M target", 32'(t1), 3); chk("R11", "mpv", 32'(mpv1), 0);
    chk("R11", "M swap", 32'(sw1), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk);
    t_u_ecall_hs();
    t_vs_ecall();
    t_forced_hs();
    t_m_ecall();
    t_m_from_virt();
    t_range();
    t_async_masks();
    t_hold();
    t_no_hyp();
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog run did not finish actual=0 expected=1");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule